// File: doc/BRIEF.md
# Bit Test and Permute Unit

This execution unit handles the bit-oriented part of a 32-bit integer datapath. Each cycle it takes two operands, a 4-bit operation code and the current status word. One clock edge later it returns a 32-bit result, a write enable for the destination register, an updated status word and a write enable for that status word. The operations are:

- a bit test that reports on a selected bit through the status flags;
- a bit mirror inside each byte;
- a swap of the bytes within each halfword;
- a swap of the two halfwords;
- a leading-zero count;
- an unsigned clamp;
- a single restoring-division step;
- three shifts that saturate when the count is larger than 31.

A decode stage feeds the opcode and operands every cycle. No handshake is needed: every clock edge captures a new operation, and the registered outputs show it until the next edge. The bit test is the only operation that changes the status word. It is also the only one that suppresses the destination write. Every other operation leaves the status word unchanged.

Top module: `bitperm_unit`

## Requirements
- R1: While rst_ni is low, result_o, stat_o, rd_we_o and stat_we_o are all zero. After reset, the outputs for the inputs present at a rising clock edge appear right after that edge.
- R2: Opcode 0 (bit test) selects bit number op_b_i[4:0] of op_a_i. The value of that bit goes to stat_o bit 3.
- R3: Opcode 0 sets stat_o bit 2 exactly when the selected bit and every bit below it in op_a_i are zero.
- R4: Opcode 0 does the following:
  - clears stat_o bit 4;
  - copies every other status bit (not 2, 3 or 4) from stat_i;
  - drives stat_we_o high and rd_we_o low;
  - puts the new status word on result_o.
- R5: Opcode 1 mirrors the bit order inside each of the four bytes of op_a_i independently.
- R6: Opcode 2 exchanges the two bytes inside each 16-bit half of op_a_i. Opcode 3 exchanges the upper and lower 16-bit halves of op_a_i.
- R7: Opcode 4 returns the number of leading zeros of op_b_i. The count is 32 when op_b_i is zero.
- R8: Opcode 5 returns op_b_i when op_a_i is greater than op_b_i as unsigned numbers, and op_a_i otherwise.
- R9: Opcode 6 shifts op_a_i left by one, keeping 32 bits. If the shifted value is greater than or equal to op_b_i (unsigned), it then subtracts op_b_i.
- R10: Opcode 7 shifts op_a_i left and opcode 8 shifts it right logically, both by op_b_i read as an unsigned count. Any count above 31 gives zero.
- R11: Opcode 9 shifts op_a_i right arithmetically by op_b_i. Any count above 31 gives all ones when op_a_i bit 31 is set, and zero otherwise.
- R12: Opcodes 10 to 15 return op_a_i unchanged with rd_we_o high, stat_o equal to stat_i, and stat_we_o low.
- R13: For opcodes 1 to 9, stat_o equals stat_i, stat_we_o is low and rd_we_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_a_i | input | 32 | First operand (data operand) |
| op_b_i | input | 32 | Second operand (bit index, count, divisor or limit) |
| opcode_i | input | 4 | Operation select |
| stat_i | input | 32 | Current status word |
| result_o | output | 32 | Registered result |
| rd_we_o | output | 1 | Destination register write enable |
| stat_o | output | 32 | Registered status word |
| stat_we_o | output | 1 | Status word write enable |

## Verification
Two effects can meet in one cycle:

- Within a single bit test, the status rewrite and the suppression of the destination write happen together.
- On the cycle after a bit test, a permute or shift must not carry the stale status update forward.

The bench provokes both:

- It issues bit tests with a fully set incoming status word, so that only flags 2 to 4 can move.
- It then places a bit test directly between other operations on consecutive clock edges.

For every cycle of that sequence, it checks both enables, the status word and the result against values computed from the requirements.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

    localparam int XLEN   = 32;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;
    localparam int SH_W   = $clog2(XLEN);

    // Status flag positions (fixed by the consumers of the status word)
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;
    localparam int FLG_X = 4;

    typedef enum logic [OP_W-1:0] {
        OP_BTST  = 4'd0,
        OP_REVB  = 4'd1,
        OP_SWPB  = 4'd2,
        OP_SWPH  = 4'd3,
        OP_LZC   = 4'd4,
        OP_BOUND = 4'd5,
        OP_DSTEP = 4'd6,
        OP_LSL   = 4'd7,
        OP_LSR   = 4'd8,
        OP_ASR   = 4'd9
    } bp_op_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic [XLEN-1:0] status;
        logic            rd_we;
        logic            st_we;
    } bp_out_t;

endpackage

// File: rtl/bitperm_perm.sv
module bitperm_perm #(
    parameter int W  = 32,
    parameter int BW = 8
) (
    input  logic [W-1:0] src_i,
    output logic [W-1:0] rev_o,
    output logic [W-1:0] swpb_o,
    output logic [W-1:0] swph_o
);
    localparam int NBYTE = W / BW;
    localparam int HALF  = W / 2;

    genvar g, k;
    generate
        for (g = 0; g < NBYTE; g++) begin : g_byte
            for (k = 0; k < BW; k++) begin : g_bit
                assign rev_o[g*BW + k] = src_i[g*BW + (BW-1-k)];
            end
        end
        for (g = 0; g < NBYTE / 2; g++) begin : g_half
            assign swpb_o[2*g*BW +: BW]     = src_i[(2*g+1)*BW +: BW];
            assign swpb_o[(2*g+1)*BW +: BW] = src_i[2*g*BW +: BW];
        end
    endgenerate

    assign swph_o = {src_i[HALF-1:0], src_i[W-1:HALF]};

endmodule

// File: rtl/bitperm_shift.sv
module bitperm_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] lsl_o,
    output logic [W-1:0] lsr_o,
    output logic [W-1:0] asr_o
);
    localparam int SW = $clog2(W);

    logic          sat;
    logic [SW-1:0] amt;

    // Any count bit at or above position SW means the count exceeds W-1
    assign sat = |cnt_i[W-1:SW];
    assign amt = cnt_i[SW-1:0];

    always_comb begin
        lsl_o = sat ? '0 : (val_i << amt);
        lsr_o = sat ? '0 : (val_i >> amt);
        asr_o = sat ? {W{val_i[W-1]}} : W'($signed(val_i) >>> amt);
    end

endmodule

// File: rtl/bitperm_arith.sv
module bitperm_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lzc_o,
    output logic [W-1:0] bound_o,
    output logic [W-1:0] dstep_o
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] zeros;
    logic [W-1:0]  dbl;

    // Ascending scan: the highest set bit is seen last and wins
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (b_i[i]) zeros = CW'(W - 1 - i);
        end
    end

    assign lzc_o   = W'(zeros);
    assign bound_o = (a_i > b_i) ? b_i : a_i;
    assign dbl     = {a_i[W-2:0], 1'b0};
    assign dstep_o = (dbl >= b_i) ? (dbl - b_i) : dbl;

endmodule

// File: rtl/bitperm_btst.sv
module bitperm_btst #(
    parameter int W  = 32,
    parameter int ZB = 2,
    parameter int NB = 3,
    parameter int XB = 4
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] idx_i,
    input  logic [W-1:0] stat_i,
    output logic [W-1:0] stat_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] sel;
    logic [W-1:0]  low_mask;
    logic          hit;
    logic          all_zero;

    assign sel = idx_i[SW-1:0];

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_mask
            assign low_mask[g] = (SW'(g) <= sel);
        end
    endgenerate

    assign hit      = data_i[sel];
    assign all_zero = ~|(data_i & low_mask);

    always_comb begin
        stat_o     = stat_i;
        stat_o[XB] = 1'b0;
        stat_o[NB] = hit;
        stat_o[ZB] = all_zero;
    end

endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
    import bitperm_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic [XLEN-1:0] stat_i,
    output logic [XLEN-1:0] result_o,
    output logic            rd_we_o,
    output logic [XLEN-1:0] stat_o,
    output logic            stat_we_o
);
    localparam logic [XLEN-1:0] KEEP_MASK =
        ~((XLEN'(1) << FLG_Z) | (XLEN'(1) << FLG_N) | (XLEN'(1) << FLG_X));

    logic [XLEN-1:0] rev_w, swpb_w, swph_w;
    logic [XLEN-1:0] lsl_w, lsr_w, asr_w;
    logic [XLEN-1:0] lzc_w, bound_w, dstep_w;
    logic [XLEN-1:0] btst_w;

    bitperm_perm #(.W(XLEN), .BW(BYTE_W)) u_perm (
        .src_i (op_a_i),
        .rev_o (rev_w),
        .swpb_o(swpb_w),
        .swph_o(swph_w)
    );

    bitperm_shift #(.W(XLEN)) u_shift (
        .val_i(op_a_i),
        .cnt_i(op_b_i),
        .lsl_o(lsl_w),
        .lsr_o(lsr_w),
        .asr_o(asr_w)
    );

    bitperm_arith #(.W(XLEN)) u_arith (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .lzc_o  (lzc_w),
        .bound_o(bound_w),
        .dstep_o(dstep_w)
    );

    bitperm_btst #(.W(XLEN), .ZB(FLG_Z), .NB(FLG_N), .XB(FLG_X)) u_btst (
        .data_i(op_a_i),
        .idx_i (op_b_i),
        .stat_i(stat_i),
        .stat_o(btst_w)
    );

    bp_out_t out_d, out_q;
    logic    started_q;

    always_comb begin
        out_d.result = op_a_i;
        out_d.status = stat_i;
        out_d.rd_we  = 1'b1;
        out_d.st_we  = 1'b0;
        case (opcode_i)
            OP_BTST: begin
                out_d.result = btst_w;
                out_d.status = btst_w;
                out_d.rd_we  = 1'b0;
                out_d.st_we  = 1'b1;
            end
            OP_REVB:  out_d.result = rev_w;
            OP_SWPB:  out_d.result = swpb_w;
            OP_SWPH:  out_d.result = swph_w;
            OP_LZC:   out_d.result = lzc_w;
            OP_BOUND: out_d.result = bound_w;
            OP_DSTEP: out_d.result = dstep_w;
            OP_LSL:   out_d.result = lsl_w;
            OP_LSR:   out_d.result = lsr_w;
            OP_ASR:   out_d.result = asr_w;
            default:  ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q     <= '0;
            started_q <= 1'b0;
        end else begin
            out_q     <= out_d;
            started_q <= 1'b1;
        end
    end

    assign result_o  = out_q.result;
    assign stat_o    = out_q.status;
    assign rd_we_o   = out_q.rd_we;
    assign stat_we_o = out_q.st_we;

    // Bit test never writes the destination and always writes status
    assert_btst_enables_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && $past(opcode_i) == OP_BTST) |-> (stat_we_o && !rd_we_o));

    // Bit test clears X and leaves non-flag bits as they came in
    assert_btst_keeps_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && $past(opcode_i) == OP_BTST) |->
        (!stat_o[FLG_X] && ((stat_o & KEEP_MASK) == ($past(stat_i) & KEEP_MASK))));

    // Only the bit test raises the status write
    assert_status_only_btst_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && $past(opcode_i) != OP_BTST) |->
        (!stat_we_o && rd_we_o && stat_o == $past(stat_i)));

    // Unused opcodes pass the first operand through
    assert_unused_passthru_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && $past(opcode_i) > OP_W'(9)) |-> (result_o == $past(op_a_i)));

    // Clamp never exceeds either operand
    assert_bound_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && $past(opcode_i) == OP_BOUND) |->
        (result_o <= $past(op_a_i) && result_o <= $past(op_b_i)));

    // Leading-zero count stays within 0..32
    assert_lzc_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && $past(opcode_i) == OP_LZC) |-> (result_o <= XLEN'(XLEN)));

    // Saturated logical shifts return zero
    assert_shift_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && ($past(opcode_i) == OP_LSL || $past(opcode_i) == OP_LSR)
         && $past(op_b_i) > XLEN'(31)) |-> (result_o == '0));

    // Division step result is below the divisor whenever the divisor is non-zero
    assert_dstep_below_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && $past(opcode_i) == OP_DSTEP && $past(op_b_i) != '0
         && $past(op_a_i) < $past(op_b_i)) |-> (result_o < $past(op_b_i)));

endmodule

// File: tb/bitperm_unit_tb.sv
module bitperm_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, stat = '0;
    logic [3:0]  opc = '0;
    logic [31:0] result, stat_out;
    logic        rd_we, stat_we;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bitperm_unit dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .opcode_i (opc),
        .stat_i   (stat),
        .result_o (result),
        .rd_we_o  (rd_we),
        .stat_o   (stat_out),
        .stat_we_o(stat_we)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Reference models written from the requirements
    function automatic logic [31:0] ref_rev(input logic [31:0] a);
        logic [31:0] r;
        for (int by = 0; by < 4; by++)
            for (int bt = 0; bt < 8; bt++)
                r[by*8 + 7 - bt] = a[by*8 + bt];
        return r;
    endfunction

    function automatic logic [31:0] ref_lzc(input logic [31:0] b);
        int n = 0;
        for (int i = 31; i >= 0; i--) begin
            if (b[i]) break;
            n++;
        end
        return 32'(n);
    endfunction

    function automatic logic [31:0] ref_btst(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] s);
        int          sel = int'(b[4:0]);
        logic [31:0] up  = a << (31 - sel);
        logic [31:0] r   = s & 32'hFFFF_FFE3;
        r[3] = up[31];
        r[2] = (up == 32'd0);
        return r;
    endfunction

    // Drive on falling edge, result registered at next rising edge, sample on next falling edge
    task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] s);
        opc = o; op_a = a; op_b = b; stat = s;
        @(negedge clk);
    endtask

    task automatic expect_data(input string tag, input logic [31:0] exp, input logic [31:0] s);
        chk({tag, " result"}, result, exp);
        chk({tag, " stat"}, stat_out, s);
        chk({tag, " rd_we"}, {31'd0, rd_we}, 32'd1);
        chk({tag, " stat_we"}, {31'd0, stat_we}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        opc = 4'd3; op_a = 32'h1234_5678; stat = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, 32'd0);
        chk("R1 reset stat", stat_out, 32'd0);
        chk("R1 reset enables", {30'd0, rd_we, stat_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_btst();
        logic [31:0] e;
        logic [31:0] pats [4] = '{32'h0000_0010, 32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF};
        logic [31:0] idx  [4] = '{32'd4, 32'd31, 32'd0, 32'h0000_0025};
        for (int i = 0; i < 4; i++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] st = s ? 32'hFFFF_FFFF : 32'h0000_0000;
                issue(4'd0, pats[i], idx[i], st);
                e = ref_btst(pats[i], idx[i], st);
                chk("R2 btst N", {31'd0, stat_out[3]}, {31'd0, e[3]});
                chk("R3 btst Z", {31'd0, stat_out[2]}, {31'd0, e[2]});
                chk("R4 btst status", stat_out, e);
                chk("R4 btst result", result, e);
                chk("R4 btst enables", {30'd0, rd_we, stat_we}, 32'd1);
            end
        end
        // Selected bit clear but a lower bit set: Z must stay low
        issue(4'd0, 32'h0000_0010, 32'd5, 32'd0);
        chk("R3 lower bit blocks Z", stat_out, 32'h0000_0000);
        // Selected bit and below all clear
        issue(4'd0, 32'hFFFF_FF00, 32'd7, 32'hFFFF_FFFF);
        chk("R3 Z set", stat_out, 32'hFFFF_FFE7);
    endtask

    task automatic t_perm();
        logic [31:0] v [3] = '{32'h0102_0380, 32'hDEAD_BEEF, 32'hF00F_5AA5};
        foreach (v[i]) begin
            issue(4'd1, v[i], 32'd0, 32'h0000_001C);
            expect_data("R5 revb", ref_rev(v[i]), 32'h0000_001C);
            issue(4'd2, v[i], 32'd0, 32'h0);
            expect_data("R6 swpb", {v[i][23:16], v[i][31:24], v[i][7:0], v[i][15:8]}, 32'h0);
            issue(4'd3, v[i], 32'd0, 32'h0);
            expect_data("R6 swph", {v[i][15:0], v[i][31:16]}, 32'h0);
        end
        issue(4'd1, 32'h0102_0380, 32'd0, 32'd0);
        chk("R5 revb const", result, 32'h8040_C001);
    endtask

    task automatic t_lzc();
        logic [31:0] v [5] = '{32'h0, 32'h1, 32'h8000_0000, 32'h0001_FFFF, 32'h00F0_0000};
        foreach (v[i]) begin
            issue(4'd4, 32'hAAAA_AAAA, v[i], 32'h5);
            expect_data("R7 lzc", ref_lzc(v[i]), 32'h5);
        end
    endtask

    task automatic t_bound();
        issue(4'd5, 32'd100, 32'd50, 32'd0);
        expect_data("R8 bound clamp", 32'd50, 32'd0);
        issue(4'd5, 32'd50, 32'd100, 32'd0);
        expect_data("R8 bound keep", 32'd50, 32'd0);
        issue(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0);
        expect_data("R8 bound unsigned", 32'h7FFF_FFFF, 32'd0);
        issue(4'd5, 32'd7, 32'd7, 32'd0);
        expect_data("R8 bound equal", 32'd7, 32'd0);
    endtask

    task automatic t_dstep();
        issue(4'd6, 32'd5, 32'd10, 32'd0);
        expect_data("R9 dstep equal", 32'd0, 32'd0);
        issue(4'd6, 32'd4, 32'd10, 32'd0);
        expect_data("R9 dstep below", 32'd8, 32'd0);
        issue(4'd6, 32'd7, 32'd10, 32'd0);
        expect_data("R9 dstep sub", 32'd4, 32'd0);
        issue(4'd6, 32'h8000_0001, 32'd1, 32'd0);
        expect_data("R9 dstep wrap", 32'd1, 32'd0);
    endtask

    task automatic t_shift();
        logic [31:0] a = 32'h8421_F00F;
        logic [31:0] c [5] = '{32'd0, 32'd1, 32'd31, 32'd32, 32'h8000_0004};
        foreach (c[i]) begin
            bit s = (c[i] > 32'd31);
            issue(4'd7, a, c[i], 32'd0);
            expect_data("R10 lsl", s ? 32'd0 : a << c[i][4:0], 32'd0);
            issue(4'd8, a, c[i], 32'd0);
            expect_data("R10 lsr", s ? 32'd0 : a >> c[i][4:0], 32'd0);
            issue(4'd9, a, c[i], 32'd0);
            expect_data("R11 asr neg", s ? 32'hFFFF_FFFF : 32'($signed(a) >>> c[i][4:0]), 32'd0);
            issue(4'd9, 32'h7000_0000, c[i], 32'd0);
            expect_data("R11 asr pos", s ? 32'd0 : 32'h7000_0000 >> c[i][4:0], 32'd0);
        end
    endtask

    task automatic t_unused();
        for (int o = 10; o < 16; o++) begin
            issue(4'(o), 32'hCAFE_0000 + 32'(o), 32'h1234, 32'h0000_001F);
            expect_data("R12 unused", 32'hCAFE_0000 + 32'(o), 32'h0000_001F);
        end
    endtask

    // Bit test placed directly between other operations on consecutive edges
    task automatic t_back_to_back();
        issue(4'd3, 32'h1111_2222, 32'd0, 32'hFFFF_FFFF);
        expect_data("R13 before btst", 32'h2222_1111, 32'hFFFF_FFFF);
        issue(4'd0, 32'h0000_0008, 32'd3, 32'hFFFF_FFFF);
        chk("R4 mid btst stat", stat_out, 32'hFFFF_FFEB);
        chk("R4 mid btst enables", {30'd0, rd_we, stat_we}, 32'd1);
        issue(4'd7, 32'd1, 32'd4, 32'h0000_0010);
        expect_data("R13 after btst", 32'd16, 32'h0000_0010);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_btst();
        t_perm();
        t_lzc();
        t_bound();
        t_dstep();
        t_shift();
        t_unused();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule